// File: doc/BRIEF.md
# Configuration Switch Output Selector with Hold Latch

This block sits behind a small non-volatile configuration word and drives six open-drain board lines. Five of the lines are switched lines. A mode select picks whether they carry the five low bits of the stored word or five external input pins. The sixth line carries the top bit of the stored word through a hold latch. The latch passes the bit straight through while the mode select is low. It freezes the bit while the mode select is high. The typical use is a pair of preset configurations: one held in the stored word and one strapped on the pins. A single control line picks between them, and the held line keeps its last shown value whenever the pins are in use.

An active-low force input pulls all six lines low. It acts only while the mode select is low. With the mode select high, the force input is ignored. Every output is a pull-down enable: a 1 pulls the line to logic 0, and a 0 releases the line so that it reads logic 1. The hold latch is modelled synchronously. It samples the shown value on every rising clock edge at which the mode select is low, so the value it freezes is the one shown at the last such edge.

Top module: `cfgsw_outmux`

## Requirements
- R1: With mode_sel = 0 and ovr_n = 1, sel_out_pd[i] = NOT cfg_word[i] for i = 0..4, with no clock delay.
- R2: With mode_sel = 1, sel_out_pd[i] = NOT ext_in[i] for i = 0..4, with no clock delay and whatever the level of ovr_n.
- R3: With mode_sel = 0 and ovr_n = 1, held_out_pd = NOT cfg_word[5], with no clock delay (the latch is transparent).
- R4: While mode_sel stays 1, held_out_pd does not change, whatever cfg_word, ext_in or ovr_n do.
- R5: After mode_sel rises, held_out_pd shows the value it had at the last rising clock edge with mode_sel = 0. A change of cfg_word[5] after that edge, made before the rise, is not captured.
- R6: With ovr_n = 0 and mode_sel = 0, all six pull-down enables are 1.
- R7: If the force was active at the last sampling edge before mode_sel rises, the held line stays pulled low (held_out_pd = 1) after the force is released, for as long as mode_sel stays 1.
- R8: While rst = 1, the latch is transparent whatever the level of mode_sel: held_out_pd = 1 if (ovr_n = 0 and mode_sel = 0), and held_out_pd = NOT cfg_word[5] otherwise. The switched outputs follow R1, R2 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold latch sampling |
| rst | input | 1 | Synchronous active-high reset; the latch is transparent while it is high |
| mode_sel | input | 1 | 0 selects the stored bits and makes the latch transparent; 1 selects the pins and holds the latch |
| ovr_n | input | 1 | Active-low force; pulls all lines low while mode_sel = 0 |
| ext_in | input | 5 | External pin values for the switched lines, bit 0 = line A |
| cfg_word | input | 6 | Stored configuration; bits 4..0 feed the switched lines, bit 5 feeds the held line |
| sel_out_pd | output | 5 | Pull-down enables of the switched lines (1 = line low) |
| held_out_pd | output | 1 | Pull-down enable of the held line (1 = line low) |

## Verification
The hardest case to reach is a capture that must miss a late change. The stored top bit has to change after the last sampling edge with the select low, and the select has to rise before the next edge. The bench drives both changes in the same low phase of the clock, between two rising edges, and then checks that the held line still shows the older value. A second sequence applies the force, lets an edge sample it, raises the select and releases the force, and then checks that the held line stays low.

// File: rtl/cfgsw_pkg.sv
package cfgsw_pkg;

    localparam int SW_WIDTH_DEF = 5;

    typedef enum logic {
        SRC_STORED = 1'b0,
        SRC_PINS   = 1'b1
    } src_e;

    // Convert a logic level to an open-drain pull-down enable.
    function automatic logic lvl_to_pd(input logic lvl);
        return ~lvl;
    endfunction

    // Decode the mode select level into the source of the switched lines.
    function automatic src_e src_from_sel(input logic sel);
        return sel ? SRC_PINS : SRC_STORED;
    endfunction

    // Pick one bit from the chosen source.
    function automatic logic pick_bit(input src_e src, input logic stored, input logic pin);
        return (src == SRC_PINS) ? pin : stored;
    endfunction

endpackage

// File: rtl/cfgsw_muxbank.sv
module cfgsw_muxbank
    import cfgsw_pkg::*;
#(
    parameter int SW_W = SW_WIDTH_DEF
) (
    input  src_e            src,
    input  logic [SW_W-1:0] stored,
    input  logic [SW_W-1:0] pins,
    output logic [SW_W-1:0] lvl
);
    for (genvar i = 0; i < SW_W; i++) begin : g_bit
        always_comb lvl[i] = pick_bit(src, stored[i], pins[i]);
    end
endmodule

// File: rtl/cfgsw_force_gate.sv
module cfgsw_force_gate
    import cfgsw_pkg::*;
#(
    parameter int SW_W = SW_WIDTH_DEF
) (
    input  logic            force_low,
    input  logic [SW_W-1:0] lvl_in,
    output logic [SW_W-1:0] pd_out
);
    for (genvar i = 0; i < SW_W; i++) begin : g_bit
        always_comb pd_out[i] = force_low ? 1'b1 : lvl_to_pd(lvl_in[i]);
    end
endmodule

// File: rtl/cfgsw_hold_latch.sv
module cfgsw_hold_latch (
    input  logic clk,
    input  logic rst,
    input  logic transparent,
    input  logic d_lvl,
    output logic q_lvl
);
    logic held_q;

    // Samples the shown value on each edge the latch is open.
    always_ff @(posedge clk) begin
        if (rst || transparent) begin
            held_q <= d_lvl;
        end
    end

    always_comb q_lvl = (rst || transparent) ? d_lvl : held_q;
endmodule

// File: rtl/cfgsw_outmux.sv
module cfgsw_outmux
    import cfgsw_pkg::*;
#(
    parameter int SW_W = SW_WIDTH_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mode_sel,
    input  logic            ovr_n,
    input  logic [SW_W-1:0] ext_in,
    input  logic [SW_W:0]   cfg_word,
    output logic [SW_W-1:0] sel_out_pd,
    output logic            held_out_pd
);
    localparam int HOLD_IDX = SW_W;

    src_e            src;
    logic            force_low;
    logic [SW_W-1:0] sw_lvl;
    logic            hold_shown;
    logic            hold_lvl;

    always_comb begin
        src        = src_from_sel(mode_sel);
        force_low  = ~ovr_n && (src == SRC_STORED);
        hold_shown = force_low ? 1'b0 : cfg_word[HOLD_IDX];
    end

    cfgsw_muxbank #(.SW_W(SW_W)) mux_i (
        .src    (src),
        .stored (cfg_word[SW_W-1:0]),
        .pins   (ext_in),
        .lvl    (sw_lvl)
    );

    cfgsw_force_gate #(.SW_W(SW_W)) gate_i (
        .force_low (force_low),
        .lvl_in    (sw_lvl),
        .pd_out    (sel_out_pd)
    );

    cfgsw_hold_latch hold_i (
        .clk         (clk),
        .rst         (rst),
        .transparent (src == SRC_STORED),
        .d_lvl       (hold_shown),
        .q_lvl       (hold_lvl)
    );

    always_comb held_out_pd = lvl_to_pd(hold_lvl);
endmodule

// File: rtl/cfgsw_outmux_chk.sv
module cfgsw_outmux_chk #(
    parameter int SW_W = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            mode_sel,
    input logic            ovr_n,
    input logic [SW_W-1:0] ext_in,
    input logic [SW_W:0]   cfg_word,
    input logic [SW_W-1:0] sel_out_pd,
    input logic            held_out_pd
);
    assert_stored_path_R1: assert property (@(posedge clk) disable iff (rst)
        (!mode_sel && ovr_n) |-> (sel_out_pd == ~cfg_word[SW_W-1:0]));

    assert_pin_path_R2: assert property (@(posedge clk) disable iff (rst)
        mode_sel |-> (sel_out_pd == ~ext_in));

    assert_transparent_R3: assert property (@(posedge clk) disable iff (rst)
        (!mode_sel && ovr_n) |-> (held_out_pd == ~cfg_word[SW_W]));

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_sel && $past(mode_sel)) |-> $stable(held_out_pd));

    assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_sel) |-> (held_out_pd == $past(held_out_pd)));

    assert_force_all_R6: assert property (@(posedge clk) disable iff (rst)
        (!ovr_n && !mode_sel) |-> ((&sel_out_pd) && held_out_pd));
endmodule

bind cfgsw_outmux cfgsw_outmux_chk #(.SW_W(SW_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .mode_sel    (mode_sel),
    .ovr_n       (ovr_n),
    .ext_in      (ext_in),
    .cfg_word    (cfg_word),
    .sel_out_pd  (sel_out_pd),
    .held_out_pd (held_out_pd)
);

// File: tb/cfgsw_outmux_tb.sv
module cfgsw_outmux_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       mode_sel;
    logic       ovr_n;
    logic [4:0] ext_in;
    logic [5:0] cfg_word;
    logic [4:0] sel_out_pd;
    logic       held_out_pd;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    cfgsw_outmux dut_i (
        .clk         (clk),
        .rst         (rst),
        .mode_sel    (mode_sel),
        .ovr_n       (ovr_n),
        .ext_in      (ext_in),
        .cfg_word    (cfg_word),
        .sel_out_pd  (sel_out_pd),
        .held_out_pd (held_out_pd)
    );

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Move to the low phase of the clock, away from the sampling edge.
    task automatic to_low();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; mode_sel = 1'b1; ovr_n = 1'b1;
        ext_in = 5'b10110; cfg_word = 6'b100000;
        repeat (2) @(posedge clk);
        to_low(); #1;
        check("R8 transparent in reset, sel high", {5'b0, held_out_pd}, 6'd0);
        check("R8/R2 switched in reset", {1'b0, sel_out_pd}, {1'b0, ~5'b10110});
        cfg_word = 6'b000000; #1;
        check("R8 follows stored bit in reset", {5'b0, held_out_pd}, 6'd1);
        to_low(); rst = 1'b0; #1;
    endtask

    task automatic t_stored();
        to_low(); mode_sel = 1'b0; ovr_n = 1'b1; cfg_word = 6'b010101; ext_in = 5'b11111; #1;
        check("R1 stored pattern a", {1'b0, sel_out_pd}, {1'b0, ~5'b10101});
        cfg_word = 6'b101010; #1;
        check("R1 stored pattern b", {1'b0, sel_out_pd}, {1'b0, ~5'b01010});
        check("R3 transparent high bit", {5'b0, held_out_pd}, 6'd0);
        cfg_word = 6'b001010; #1;
        check("R3 transparent low bit", {5'b0, held_out_pd}, 6'd1);
    endtask

    task automatic t_pins();
        to_low(); mode_sel = 1'b1; ext_in = 5'b00111; #1;
        check("R2 pins pattern a", {1'b0, sel_out_pd}, {1'b0, ~5'b00111});
        ext_in = 5'b11000; ovr_n = 1'b0; #1;
        check("R2 pins with force ignored", {1'b0, sel_out_pd}, {1'b0, ~5'b11000});
        ovr_n = 1'b1;
    endtask

    task automatic t_capture();
        to_low(); mode_sel = 1'b0; ovr_n = 1'b1; cfg_word = 6'b100000;
        @(posedge clk); to_low();
        mode_sel = 1'b1; #1;
        check("R5 capture high", {5'b0, held_out_pd}, 6'd0);
        cfg_word = 6'b000000; ovr_n = 1'b0; ext_in = 5'b01010;
        repeat (3) @(posedge clk); to_low();
        check("R4 hold while sel high", {5'b0, held_out_pd}, 6'd0);
        ovr_n = 1'b1;
    endtask

    task automatic t_stale();
        to_low(); mode_sel = 1'b0; cfg_word = 6'b000000;
        @(posedge clk); to_low();
        cfg_word = 6'b100000; #1;
        check("R3 late change shown", {5'b0, held_out_pd}, 6'd0);
        mode_sel = 1'b1; #1;
        check("R5 late change not captured", {5'b0, held_out_pd}, 6'd1);
        @(posedge clk); to_low();
        check("R4 stale value kept", {5'b0, held_out_pd}, 6'd1);
    endtask

    task automatic t_force();
        to_low(); mode_sel = 1'b0; ovr_n = 1'b0; cfg_word = 6'b111111; #1;
        check("R6 switched forced low", {1'b0, sel_out_pd}, 6'b011111);
        check("R6 held forced low", {5'b0, held_out_pd}, 6'd1);
        @(posedge clk); to_low();
        mode_sel = 1'b1; ovr_n = 1'b1; ext_in = 5'b11111; #1;
        check("R7 forced low captured", {5'b0, held_out_pd}, 6'd1);
        check("R2 after force release", {1'b0, sel_out_pd}, 6'd0);
        repeat (2) @(posedge clk); to_low();
        check("R7 forced low kept", {5'b0, held_out_pd}, 6'd1);
        mode_sel = 1'b0; #1;
        check("R3 reopened latch", {5'b0, held_out_pd}, 6'd0);
    endtask

    initial begin
        t_reset();
        t_stored();
        t_pins();
        t_capture();
        t_stale();
        t_force();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule